// File: doc/BRIEF.md
# Endpoint Stall Control Register

This block holds the firmware-controlled stall state of the four endpoints of a USB function controller. Firmware writes one byte on a simple register bus to put any endpoint into or out of the stall state. The packet engine reports three things to the block: a pending setup packet, an 8-byte setup command that the function decoded by itself, and the start of a transaction on each endpoint. In return the block gives the handshake generator a per-endpoint answer of STALL, ACK or NAK.

The stall bit of each endpoint is captured when a transaction starts and held until the next one starts. A write made while a transaction is in progress therefore affects only the next transaction. The control endpoint has extra rules:
- Its stall bit is cleared by hardware when the function decodes a setup command.
- A write that tries to set that bit is dropped while a setup packet is still pending.

The block also turns a firmware request to flush the third endpoint's FIFO into a one-cycle pulse toward that FIFO. The pulse is withheld while DMA writes into that FIFO are enabled.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After reset, every stall bit is 0, a read at address 0 returns 8'h00, `stall_req` is 0, and with `fifo_ready` low every endpoint's handshake code is NAK (2'b00).
- R2: A write at address 0 stores bit 0 as the EP0 stall, bit 4 as EP1, bit 5 as EP2 and bit 3 as EP3. Writing 1 sets a stall and writing 0 cancels it. Bits 1, 2, 6 and 7 always read 0, so writing 8'hFF reads back 8'h39.
- R3: `stall_req[i]` equals the stored stall bit of endpoint i, one cycle after the write.
- R4: A one-cycle `setup_decoded` pulse clears the EP0 stall bit in the following cycle and leaves the other endpoints unchanged.
- R5: While `setup_pend` is 1, a write of 1 to the EP0 stall bit leaves that bit at 0. The other bits of the same write still take effect, and a write of 0 still cancels an EP0 stall.
- R6: When `setup_decoded` and a write setting the EP0 stall bit arrive in the same cycle, the EP0 stall bit is 0 afterwards.
- R7: On a `txn_start[i]` pulse, endpoint i captures its stall bit. Its code in `hs_code[2i+1:2i]` is then STALL (2'b10) if the captured bit is 1, otherwise ACK (2'b01) if `fifo_ready[i]` is 1, otherwise NAK (2'b00). Before any transaction has started, the captured bit is 0.
- R8: A stall write made after a transaction has started does not change that endpoint's handshake code until its next `txn_start` pulse.
- R9: A write at address 1 with bit 2 set, while `dma_mode` is 2'b00, gives exactly one cycle of `ep2_fifo_clr` in the cycle after the write. Address 1 always reads 8'h00.
- R10: While `dma_mode` is 2'b10, 2'b11 or 2'b01, a FIFO-clear write gives no `ep2_fifo_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 = stall, 1 = FIFO clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| setup_pend | input | 1 | Setup packet received and not yet serviced |
| setup_decoded | input | 1 | Pulse: 8-byte setup command decoded by the function |
| txn_start | input | 4 | Pulse per endpoint: a transaction begins |
| fifo_ready | input | 4 | Per-endpoint FIFO can accept or supply data |
| dma_mode | input | 2 | DMA transfer type for the EP2 FIFO |
| stall_req | output | 4 | Current stall bit per endpoint |
| hs_code | output | 8 | Handshake code, two bits per endpoint |
| ep2_fifo_clr | output | 1 | One-cycle clear pulse to the EP2 FIFO |

## Verification
The stall register is written with 8'hFF, 8'h00 and single-endpoint patterns. These separate a correct bit map from swapped or missing positions, and show that the reserved bits stay at 0. The control endpoint is exercised in three ways: an auto-clear on its own, a set attempt while a setup is pending, and an auto-clear in the same cycle as a set write. Together these show which of the competing updates wins. The handshake is checked with FIFOs ready and not ready, and with a stall write between two transaction starts, which shows whether the code follows the captured bit or the live one. The FIFO clear is requested under all four `dma_mode` values to show that only 2'b00 lets the pulse through.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
    localparam int NUM_EP = 4;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        HS_NAK   = 2'b00,
        HS_ACK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    // Position of each endpoint's stall bit inside the register byte.
    function automatic int ep_bit(input int ep);
        case (ep)
            0:       return 0;
            1:       return 4;
            2:       return 5;
            3:       return 3;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/stall_reg_file.sv
module stall_reg_file
    import ep_stall_pkg::*;
#(
    parameter int N_EP = NUM_EP,
    parameter int W    = REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wdata,
    input  logic            setup_pend,
    input  logic            setup_decoded,
    output logic [N_EP-1:0] stall_ep,
    output logic [W-1:0]    reg_val
);
    typedef struct packed {
        logic [N_EP-1:0] stall;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < N_EP; i++) begin
                // A set of the control endpoint is dropped while a setup is pending.
                if (!(i == 0 && wdata[ep_bit(i)] && setup_pend)) begin
                    st_d.stall[i] = wdata[ep_bit(i)];
                end
            end
        end
        // The hardware clear of the control endpoint overrides any write.
        if (setup_decoded) begin
            st_d.stall[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_val = '0;
        for (int i = 0; i < N_EP; i++) begin
            reg_val[ep_bit(i)] = st_q.stall[i];
        end
    end

    assign stall_ep = st_q.stall;

    a_r4_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        setup_decoded |=> !stall_ep[0]);

    a_r5_set_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && setup_pend && !stall_ep[0]) |=> !stall_ep[0]);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[0] && setup_decoded) |=> !stall_ep[0]);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !setup_decoded) |=> $stable(stall_ep));
endmodule

// File: rtl/hs_sampler.sv
module hs_sampler
    import ep_stall_pkg::*;
#(
    parameter int N_EP = NUM_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EP-1:0]   txn_start,
    input  logic [N_EP-1:0]   stall_ep,
    input  logic [N_EP-1:0]   fifo_ready,
    output logic [2*N_EP-1:0] hs_code
);
    typedef struct packed {
        logic [N_EP-1:0] held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_EP; i++) begin
            if (txn_start[i]) st_d.held[i] = stall_ep[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_EP; g++) begin : g_ep
        hs_e code;
        always_comb begin
            if (st_q.held[g])       code = HS_STALL;
            else if (fifo_ready[g]) code = HS_ACK;
            else                    code = HS_NAK;
        end
        assign hs_code[2*g+1 -: 2] = code;

        a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
            txn_start[g] |=> (hs_code[2*g+1 -: 2] == HS_STALL) == $past(stall_ep[g]));

        a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
            (!txn_start[g] && hs_code[2*g+1 -: 2] == HS_STALL) |=>
                hs_code[2*g+1 -: 2] == HS_STALL);
    end
endmodule

// File: rtl/fifo_clr_gate.sv
module fifo_clr_gate #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic [MODE_W-1:0] dma_mode,
    output logic              clr_pulse
);
    typedef struct packed {
        logic pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.pulse = clr_req && (dma_mode == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_pulse = st_q.pulse;

    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !$past(clr_req)) |-> 1'b0);

    a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && dma_mode != '0) |=> !clr_pulse);
endmodule

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl
    import ep_stall_pkg::*;
#(
    parameter int N_EP    = NUM_EP,
    parameter int W       = REG_W,
    parameter int CLR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              setup_pend,
    input  logic              setup_decoded,
    input  logic [N_EP-1:0]   txn_start,
    input  logic [N_EP-1:0]   fifo_ready,
    input  logic [1:0]        dma_mode,
    output logic [N_EP-1:0]   stall_req,
    output logic [2*N_EP-1:0] hs_code,
    output logic              ep2_fifo_clr
);
    localparam logic [1:0] ADDR_STALL = 2'd0;
    localparam logic [1:0] ADDR_CLR   = 2'd1;

    logic          stall_wr;
    logic          clr_req;
    logic [W-1:0]  stall_val;

    assign stall_wr = bus_wr && (bus_addr == ADDR_STALL);
    assign clr_req  = bus_wr && (bus_addr == ADDR_CLR) && bus_wdata[CLR_BIT];

    stall_reg_file #(.N_EP(N_EP), .W(W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (stall_wr),
        .wdata         (bus_wdata),
        .setup_pend    (setup_pend),
        .setup_decoded (setup_decoded),
        .stall_ep      (stall_req),
        .reg_val       (stall_val)
    );

    hs_sampler #(.N_EP(N_EP)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .stall_ep   (stall_req),
        .fifo_ready (fifo_ready),
        .hs_code    (hs_code)
    );

    fifo_clr_gate #(.MODE_W(2)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (clr_req),
        .dma_mode  (dma_mode),
        .clr_pulse (ep2_fifo_clr)
    );

    // The clear register is write-only; every address except the stall register reads 0.
    always_comb begin
        bus_rdata = (bus_addr == ADDR_STALL) ? stall_val : '0;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_STALL) |-> (bus_rdata & 8'hC6) == 8'h00);
endmodule

// File: tb/ep_stall_ctrl_tb.sv
module ep_stall_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       setup_pend = 1'b0;
    logic       setup_decoded = 1'b0;
    logic [3:0] txn_start = 4'h0;
    logic [3:0] fifo_ready = 4'h0;
    logic [1:0] dma_mode = 2'b00;
    logic [3:0] stall_req;
    logic [7:0] hs_code;
    logic       ep2_fifo_clr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ep_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .setup_pend(setup_pend),
        .setup_decoded(setup_decoded), .txn_start(txn_start),
        .fifo_ready(fifo_ready), .dma_mode(dma_mode), .stall_req(stall_req),
        .hs_code(hs_code), .ep2_fifo_clr(ep2_fifo_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one write for a single cycle; returns at the falling edge after it is registered.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 2'd0;
    endtask

    task automatic txn(input logic [3:0] eps);
        @(negedge clk);
        txn_start = eps;
        @(negedge clk);
        txn_start = 4'h0;
    endtask

    task automatic t_reset();
        rd_check("R1 reset read", 2'd0, 8'h00);
        check("R1 reset stall_req", stall_req, 4'h0);
        check("R1 reset hs NAK", hs_code, 8'h00);
    endtask

    task automatic t_map();
        wr(2'd0, 8'hFF);
        rd_check("R2 write FF reads 39", 2'd0, 8'h39);
        check("R3 all stalls", stall_req, 4'hF);
        wr(2'd0, 8'h00);
        rd_check("R2 write 00 cancels", 2'd0, 8'h00);
        wr(2'd0, 8'h10);
        check("R3 bit4 is EP1", stall_req, 4'b0010);
        wr(2'd0, 8'h20);
        check("R3 bit5 is EP2", stall_req, 4'b0100);
        wr(2'd0, 8'h08);
        check("R3 bit3 is EP3", stall_req, 4'b1000);
        wr(2'd0, 8'h06);
        check("R2 reserved bits ignored", stall_req, 4'b0000);
    endtask

    task automatic t_autoclear();
        wr(2'd0, 8'h39);
        @(negedge clk);
        setup_decoded = 1'b1;
        @(negedge clk);
        setup_decoded = 1'b0;
        check("R4 EP0 auto-cleared", stall_req, 4'b1110);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_setup_block();
        setup_pend = 1'b1;
        wr(2'd0, 8'h11);
        check("R5 EP0 set dropped, EP1 set", stall_req, 4'b0010);
        setup_pend = 1'b0;
        wr(2'd0, 8'h01);
        check("R5 EP0 set after pending ends", stall_req, 4'b0001);
        setup_pend = 1'b1;
        wr(2'd0, 8'h00);
        check("R5 write 0 cancels while pending", stall_req, 4'b0000);
        setup_pend = 1'b0;
    endtask

    task automatic t_collision();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h21; setup_decoded = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00; setup_decoded = 1'b0;
        check("R6 auto-clear beats write", stall_req, 4'b0100);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_handshake();
        fifo_ready = 4'hF;
        #1;
        check("R7 ACK before any txn", hs_code, 8'h55);
        wr(2'd0, 8'h10);
        check("R7 no capture without txn", hs_code, 8'h55);
        txn(4'hF);
        check("R7 EP1 STALL others ACK", hs_code, 8'h59);
        fifo_ready = 4'h0;
        #1;
        check("R7 EP1 STALL others NAK", hs_code, 8'h08);
        fifo_ready = 4'hF;
    endtask

    task automatic t_mid_txn();
        wr(2'd0, 8'h00);
        check("R8 live bit cleared", stall_req, 4'h0);
        check("R8 code still STALL", hs_code[3:2], 2'b10);
        wr(2'd0, 8'h01);
        check("R8 EP0 not yet STALL", hs_code[1:0], 2'b01);
        txn(4'b0011);
        check("R8 next txn takes new bits", hs_code, 8'h56);
        wr(2'd0, 8'h00);
        txn(4'hF);
        check("R8 all back to ACK", hs_code, 8'h55);
    endtask

    task automatic t_fifo_clr();
        dma_mode = 2'b00;
        wr(2'd1, 8'h04);
        check("R9 clear pulse", ep2_fifo_clr, 1'b1);
        @(negedge clk);
        check("R9 pulse one cycle", ep2_fifo_clr, 1'b0);
        rd_check("R9 clear reg reads 0", 2'd1, 8'h00);
        wr(2'd1, 8'hFB);
        check("R9 other bits no pulse", ep2_fifo_clr, 1'b0);
    endtask

    task automatic t_fifo_blocked();
        for (int m = 1; m < 4; m++) begin
            dma_mode = 2'(m);
            wr(2'd1, 8'h04);
            check("R10 blocked by DMA", ep2_fifo_clr, 1'b0);
        end
        dma_mode = 2'b00;
        wr(2'd1, 8'h04);
        check("R10 allowed after DMA off", ep2_fifo_clr, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_autoclear();
        t_setup_block();
        t_collision();
        t_handshake();
        t_mid_txn();
        t_fifo_clr();
        t_fifo_blocked();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule